// File: doc/BRIEF.md
# Line-Allocate Store Replay Buffer

This block keeps an ordered record of the stores issued by a cache-line-allocate operation, so that each one can be written back to memory if its line is invalidated before it reaches memory. Every cacheable store is recorded with its full address and data, and records are kept oldest first in a small fixed-depth buffer. A store whose address is not cacheable leaves no record.

An invalidate request names an address. The buffer is searched from the oldest record to the newest, and the first record whose line address matches is replayed on a memory write port with a valid/ready handshake. Two addresses are in the same line when they are equal after their low `LINE_BITS` bits are cleared. Once memory accepts the write, that record is removed and the records behind it move up one place, so the order of the rest is kept. Only that one record is replayed. A discard request empties the whole buffer and writes nothing.

The block accepts one request per cycle. While a replay write is waiting for acceptance, the block reports `busy` and ignores all requests.

Top module: `lalloc_store_buf`

## Requirements
- R1: After reset the buffer holds no records (`count` = 0), `wr_valid` is 0 and `overflow` is 0.
- R2: A push with `push_cacheable` = 1, accepted while the buffer is idle and not full, appends a record at the tail and raises `count` by one in the next cycle.
- R3: A push with `push_cacheable` = 0 is ignored: `count` is unchanged and no record is added.
- R4: An invalidate replays the oldest record whose address bits [31:LINE_BITS] equal those of `inv_addr`. `wr_valid` rises in the cycle after the request, and `wr_addr` and `wr_data` carry that record's own stored address and data.
- R5: Only the first matching record is replayed. Any later records in the same line stay in the buffer in their order.
- R6: A replay write holds `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` is 1. The record is removed, and `count` falls by one, only in the cycle after acceptance.
- R7: Records behind a removed record each move one place toward the head in a single cycle, so the order is kept. The next push goes into the freed tail position.
- R8: An invalidate that matches no record produces no write, leaves `busy` at 0 in the next cycle and leaves `count` unchanged.
- R9: A discard empties the buffer (`count` = 0) in the next cycle. When requests arrive in the same cycle, discard comes first, then invalidate, then push; the requests that lose are dropped.
- R10: A cacheable push made when `count` = DEPTH is dropped and sets `overflow`. `overflow` stays at 1 until reset.
- R11: While `busy` = 1, push, invalidate and discard requests are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Store record request |
| push_addr | input | AW | Store address |
| push_data | input | DW | Store data |
| push_cacheable | input | 1 | Store address is cacheable |
| inv_valid | input | 1 | Line invalidate request |
| inv_addr | input | AW | Address inside the line being invalidated |
| discard | input | 1 | Empty the whole buffer |
| wr_valid | output | 1 | Replay write pending |
| wr_addr | output | AW | Replay write address |
| wr_data | output | DW | Replay write data |
| wr_ready | input | 1 | Memory accepts the replay write |
| busy | output | 1 | Replay in progress; requests are ignored |
| count | output | $clog2(DEPTH+1) | Number of records held |
| overflow | output | 1 | Sticky: a push was dropped because the buffer was full |

## Verification
The invalidate path is driven with several patterns, and each one separates a different kind of fault. A line holding several records checks that only the oldest is replayed and that the rest survive in order. A match in the middle of the buffer checks that the gap closes and that the next push goes to the tail. An address in the same line at a different word offset checks that only the line bits are compared, and an unmatched line checks that nothing is written. A stalled `wr_ready`, with requests issued during the stall, checks that the write holds steady and that those requests are ignored. Same-cycle request combinations check the order in which requests win.

// File: rtl/lalloc_store_buf.sv
module lalloc_store_buf #(
  parameter int DEPTH     = 4,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       push_cacheable,
  input  logic                       inv_valid,
  input  logic [AW-1:0]              inv_addr,
  input  logic                       discard,
  output logic                       wr_valid,
  output logic [AW-1:0]              wr_addr,
  output logic [DW-1:0]              wr_data,
  input  logic                       wr_ready,
  output logic                       busy,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [IW-1:0] sel;
  logic [IW-1:0] hit_idx;
  logic          hit;

  wire full      = (count == CW'(DEPTH));
  wire take_disc = !busy && discard;
  wire take_inv  = !busy && !discard && inv_valid;
  wire take_push = !busy && !discard && !inv_valid && push_valid && push_cacheable;
  wire accept    = busy && wr_ready;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CW'(i) < count &&
          ent_addr[i][AW-1:LINE_BITS] == inv_addr[AW-1:LINE_BITS]) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign wr_valid = busy;
  assign wr_addr  = ent_addr[sel];
  assign wr_data  = ent_data[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sel      <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b0;
      count <= count - 1'b1;
    end else if (take_disc) begin
      count <= '0;
    end else if (take_inv) begin
      if (hit) begin
        busy <= 1'b1;
        sel  <= hit_idx;
      end
    end else if (take_push) begin
      if (full) overflow <= 1'b1;
      else      count    <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= sel) begin
          ent_addr[i] <= ent_addr[i+1];
          ent_data[i] <= ent_data[i+1];
        end
      end
    end else if (take_push && !full) begin
      ent_addr[count[IW-1:0]] <= push_addr;
      ent_data[count[IW-1:0]] <= push_data;
    end
  end
endmodule

// File: rtl/lalloc_store_buf_chk.sv
module lalloc_store_buf_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          push_cacheable,
  input logic          inv_valid,
  input logic          discard,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_ready,
  input logic          busy,
  input logic [CW-1:0] count,
  input logic          overflow
);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_noncache_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !discard && !inv_valid && push_valid && !push_cacheable) |=> $stable(count));

  a_r6_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r6_remove_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid && count == $past(count) - 1'b1));

  a_r9_discard_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && discard) |=> (count == '0));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));

  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_ready) |=> $stable(count));
endmodule

bind lalloc_store_buf lalloc_store_buf_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .CW($clog2(DEPTH+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_cacheable(push_cacheable),
  .inv_valid(inv_valid), .discard(discard), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .count(count), .overflow(overflow)
);

// File: tb/lalloc_store_buf_tb.sv
module lalloc_store_buf_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, push_cacheable = 1'b0;
  logic [31:0] push_addr = '0, push_data = '0, inv_addr = '0;
  logic        inv_valid = 1'b0, discard = 1'b0, wr_ready = 1'b1;
  logic        wr_valid, busy, overflow;
  logic [31:0] wr_addr, wr_data;
  logic [2:0]  count;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_addr[$], m_data[$];
  logic [63:0] exp_q[$];

  always #10 clk = ~clk;

  lalloc_store_buf #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R4 replay write", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic do_push(input logic [31:0] a, input logic [31:0] d, input bit c);
    @(negedge clk);
    push_valid = 1; push_addr = a; push_data = d; push_cacheable = c;
    @(negedge clk);
    push_valid = 0;
    if (c && m_addr.size() < DEPTH) begin m_addr.push_back(a); m_data.push_back(d); end
  endtask

  task automatic model_inv(input logic [31:0] a);
    for (int i = 0; i < m_addr.size(); i++)
      if (m_addr[i][31:5] == a[31:5]) begin
        exp_q.push_back({m_addr[i], m_data[i]});
        m_addr.delete(i); m_data.delete(i);
        break;
      end
  endtask

  task automatic do_inv(input logic [31:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
    model_inv(a);
    while (busy) @(negedge clk);
  endtask

  task automatic chk_count(input string req);
    check(count == 3'(m_addr.size()), req, count, m_addr.size());
  endtask

  initial begin
    #4_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(count == 0 && !wr_valid && !overflow, "R1 reset state", {count, wr_valid, overflow}, 0);

    do_push(32'h1000_0004, 32'hA1, 1); chk_count("R2 append");
    do_push(32'h2000_0000, 32'hB2, 0); chk_count("R3 noncacheable ignored");
    do_push(32'h1000_0018, 32'hA2, 1);
    do_push(32'h3000_0040, 32'hC1, 1);
    do_push(32'h1000_0008, 32'hA3, 1); chk_count("R2 fill");
    do_push(32'h4000_0000, 32'hD1, 1);
    check(overflow == 1'b1, "R10 overflow set", overflow, 1); chk_count("R10 dropped");

    do_inv(32'h1000_001C); chk_count("R5 single replay");
    do_inv(32'h5000_0000);
    check(!busy, "R8 no match idle", busy, 0); chk_count("R8 count kept");
    do_inv(32'h3000_0050); chk_count("R7 mid removal");
    do_push(32'h6000_0000, 32'hE1, 1); chk_count("R7 push to tail");
    // R7: order check by replaying remaining records oldest first
    do_inv(32'h1000_0000);
    do_inv(32'h1000_0000);
    do_inv(32'h6000_0000); chk_count("R7 order kept");
    check(overflow == 1'b1, "R10 sticky", overflow, 1);

    do_push(32'h7000_0000, 32'h71, 1);
    do_push(32'h7000_0004, 32'h72, 1);
    wr_ready = 0;
    @(negedge clk); inv_valid = 1; inv_addr = 32'h7000_0000;
    @(negedge clk); inv_valid = 0; model_inv(32'h7000_0000);
    begin
      logic [31:0] ha;
      ha = wr_addr;
      push_valid = 1; push_cacheable = 1; push_addr = 32'h8000_0000; discard = 1;
      repeat (3) @(negedge clk);
      push_valid = 0; discard = 0;
      check(wr_valid && wr_addr == ha, "R6 hold while stalled", wr_addr, ha);
      check(count == 2, "R11 busy ignores", count, 2);
    end
    wr_ready = 1;
    while (busy) @(negedge clk);
    chk_count("R6 removed after accept");

    @(negedge clk); discard = 1; push_valid = 1; push_cacheable = 1; push_addr = 32'h9000_0000;
    @(negedge clk); discard = 0; push_valid = 0;
    m_addr.delete(); m_data.delete();
    chk_count("R9 discard wins");

    do_push(32'hA000_0000, 32'h11, 1);
    @(negedge clk); inv_valid = 1; inv_addr = 32'hA000_0010; push_valid = 1; push_addr = 32'hB000_0000;
    @(negedge clk); inv_valid = 0; push_valid = 0; model_inv(32'hA000_0010);
    while (busy) @(negedge clk);
    chk_count("R9 invalidate beats push");

    check(exp_q.size() == 0, "R4 all replays seen", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule